// File: doc/BRIEF.md
# Windowed FIR Coefficient Builder

This block turns a fixed, long ideal low-pass impulse response into a short set of FIR taps entirely in hardware. The ideal response is a constant table centred on its middle sample. When a rebuild is requested, the block takes a tap count N and then consumes N window values, one per accepted beat, from an integer-sequence window source. Each window value is multiplied by the ideal sample at the matching position of an N-wide slice centred on the table. The product is rounded and saturated, then written to an external coefficient memory through a simple write port.

A filter datapath elsewhere reads that memory. Retuning the transition width means only issuing a new start with a different N, or feeding a different window sequence. The window input is a valid/ready stream. A beat transfers on a rising edge where both `win_valid_i` and `win_ready_o` are high. The source may hold valid low for any number of cycles, and the block simply waits. The block drops ready when no build is in progress, once N beats have transferred, and in any cycle where start is high. The write port has no back-pressure: the memory must accept a write on every cycle where `coef_we_o` is high.

Top module: `wcb_coef_builder`

## Requirements
- R1: While reset is held and on the first cycle after it, `win_ready_o`, `coef_we_o` and `done_o` are low.
- R2: A start pulse captures the tap count. From the next cycle, ready is high until exactly N beats have been accepted. Exactly N writes follow, to addresses 0, 1, …, N−1 in that order.
- R3: The coefficient written at address k equals sat(round(h[C − ⌊N/2⌋ + k] · w_k / 2^FRAC)). Here C = IDEAL_DEPTH/2 and w_k is the k-th accepted window value (unsigned). The ideal sample is h[a] = ((a·1237 + 91) mod 65536) − 32768.
- R4: Rounding adds 2^(FRAC−1) to the signed product and then shifts arithmetically right by FRAC. This is round-half-up, and it also applies to negative products.
- R5: A rounded value outside the signed COEF_W range is clamped to −2^(COEF_W−1) or 2^(COEF_W−1)−1.
- R6: Each write appears exactly one cycle after its beat is accepted. Idle cycles on the window stream give gaps in the writes, and there is no write without an accepted beat.
- R7: `done_o` is a single-cycle pulse in the cycle after the N-th write. When N is 0, no write occurs and done pulses on the second cycle after the start edge.
- R8: A requested tap count above MAX_TAPS is treated as MAX_TAPS.
- R9: A start during a build aborts it. No write appears in the cycle after the start edge, and the new build begins again at address 0.
- R10: Window beats offered while no build is in progress, or during a start cycle, are not accepted and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin (or restart) a build |
| taps_i | input | $clog2(MAX_TAPS+1) | Requested tap count, sampled with start |
| win_valid_i | input | 1 | Window value present |
| win_ready_o | output | 1 | Block accepts a window value |
| win_data_i | input | WIN_W | Unsigned window value |
| coef_we_o | output | 1 | Coefficient write enable |
| coef_addr_o | output | $clog2(MAX_TAPS+1) | Coefficient write address |
| coef_data_o | output | COEF_W | Signed coefficient value |
| done_o | output | 1 | One-cycle build-complete pulse |

## Verification
Ready becomes visible in the first cycle after the start edge. Each write follows its accepted beat by one edge, and done follows the last write by one edge. A zero-tap build raises done two edges after start. The bench samples every output on the falling edge and keeps its own cycle counter. It checks the write address and data against the bench's own model on each write. It checks that the cycle recorded for done is exactly one past the cycle of the last write, or one past the start edge for zero taps. The cycle right after an aborting start is checked directly for the absence of a write.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  localparam int IDEAL_W = 16;

  // Stand-in ideal response: a fixed arithmetic pattern spanning the full
  // signed 16-bit range, computed rather than tabulated.
  function automatic logic signed [IDEAL_W-1:0] ideal_sample(input logic [31:0] k);
    logic [31:0] t;
    t = k * 32'd1237 + 32'd91;
    return signed'({~t[15], t[14:0]});
  endfunction

endpackage

// File: rtl/wcb_ideal_rom.sv
module wcb_ideal_rom #(
  parameter int AW = 13
) (
  input  logic [AW-1:0]                        addr_i,
  output logic signed [wcb_pkg::IDEAL_W-1:0]   data_o
);
  assign data_o = wcb_pkg::ideal_sample(32'(addr_i));
endmodule

// File: rtl/wcb_scaler.sv
module wcb_scaler #(
  parameter int IW   = 16,
  parameter int WW   = 10,
  parameter int CW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [IW-1:0] ideal_i,
  input  logic [WW-1:0]        win_i,
  output logic signed [CW-1:0] coef_o
);
  localparam int PW = IW + WW + 1;
  localparam logic signed [PW-1:0] CMAX = PW'((64'sd1 <<< (CW-1)) - 64'sd1);
  localparam logic signed [PW-1:0] CMIN = -CMAX - PW'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shf;

  assign prod = ideal_i * $signed({1'b0, win_i});

  generate
    if (FRAC > 0) begin : g_round
      localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC-1);
      assign shf = (prod + HALF) >>> FRAC;
    end else begin : g_exact
      assign shf = prod;
    end
  endgenerate

  always_comb begin
    if (shf > CMAX)      coef_o = CMAX[CW-1:0];
    else if (shf < CMIN) coef_o = CMIN[CW-1:0];
    else                 coef_o = shf[CW-1:0];
  end
endmodule

// File: rtl/wcb_sequencer.sv
module wcb_sequencer #(
  parameter int DEPTH    = 8192,
  parameter int MAX_TAPS = 512,
  parameter int AW       = $clog2(DEPTH),
  parameter int TW       = $clog2(MAX_TAPS+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] taps_i,
  input  logic          win_valid_i,
  output logic          win_ready_o,
  output logic          accept_o,
  output logic [TW-1:0] idx_o,
  output logic          last_o,
  output logic          zero_start_o,
  output logic [AW-1:0] rom_addr_o
);
  localparam logic [AW-1:0] CENTER = AW'(DEPTH / 2);
  localparam logic [TW-1:0] TMAX   = TW'(MAX_TAPS);

  logic [TW-1:0] n_q, idx_q, n_eff;
  logic [AW-1:0] base_q;
  logic          busy_q;

  assign n_eff        = (taps_i > TMAX) ? TMAX : taps_i;
  assign win_ready_o  = busy_q && !start_i;
  assign accept_o     = win_ready_o && win_valid_i;
  assign last_o       = (TW'(idx_q + 1'b1) == n_q);
  assign idx_o        = idx_q;
  assign zero_start_o = start_i && (n_eff == '0);
  assign rom_addr_o   = base_q + AW'(idx_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      n_q    <= '0;
      idx_q  <= '0;
      base_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      n_q    <= n_eff;
      idx_q  <= '0;
      base_q <= CENTER - AW'(n_eff >> 1);
      busy_q <= (n_eff != '0);
    end else if (accept_o) begin
      idx_q <= idx_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

  // R8
  taps_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (n_q <= TMAX && idx_q < n_q));

endmodule

// File: rtl/wcb_coef_builder.sv
module wcb_coef_builder #(
  parameter int IDEAL_DEPTH = 8192,
  parameter int MAX_TAPS    = 512,
  parameter int WIN_W       = 10,
  parameter int COEF_W      = 16,
  parameter int FRAC        = 8,
  localparam int AW         = $clog2(IDEAL_DEPTH),
  localparam int TW         = $clog2(MAX_TAPS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TW-1:0]     taps_i,
  input  logic              win_valid_i,
  output logic              win_ready_o,
  input  logic [WIN_W-1:0]  win_data_i,
  output logic              coef_we_o,
  output logic [TW-1:0]     coef_addr_o,
  output logic [COEF_W-1:0] coef_data_o,
  output logic              done_o
);
  logic                               accept, last, zero_start;
  logic [TW-1:0]                      idx;
  logic [AW-1:0]                      rom_addr;
  logic signed [wcb_pkg::IDEAL_W-1:0] ideal;
  logic signed [COEF_W-1:0]           scaled;

  logic              we_q, last_q, zero_pend_q, done_q;
  logic [TW-1:0]     addr_q;
  logic [COEF_W-1:0] data_q;

  wcb_sequencer #(.DEPTH(IDEAL_DEPTH), .MAX_TAPS(MAX_TAPS), .AW(AW), .TW(TW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .taps_i       (taps_i),
    .win_valid_i  (win_valid_i),
    .win_ready_o  (win_ready_o),
    .accept_o     (accept),
    .idx_o        (idx),
    .last_o       (last),
    .zero_start_o (zero_start),
    .rom_addr_o   (rom_addr)
  );

  wcb_ideal_rom #(.AW(AW)) u_rom (
    .addr_i (rom_addr),
    .data_o (ideal)
  );

  wcb_scaler #(.IW(wcb_pkg::IDEAL_W), .WW(WIN_W), .CW(COEF_W), .FRAC(FRAC)) u_scale (
    .ideal_i (ideal),
    .win_i   (win_data_i),
    .coef_o  (scaled)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      we_q        <= 1'b0;
      last_q      <= 1'b0;
      zero_pend_q <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
    end else begin
      done_q      <= !start_i && ((we_q && last_q) || zero_pend_q);
      zero_pend_q <= zero_start;
      we_q        <= accept && !start_i;
      if (accept) begin
        addr_q <= idx;
        data_q <= scaled;
        last_q <= last;
      end
    end
  end

  assign coef_we_o   = we_q;
  assign coef_addr_o = addr_q;
  assign coef_data_o = data_q;
  assign done_o      = done_q;

  // R6
  write_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> $past(win_valid_i && win_ready_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !win_ready_o);

  // R9
  abort_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> !coef_we_o);

endmodule

// File: tb/wcb_coef_builder_bench.sv
module wcb_coef_builder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64, MAXT = 16, WW = 8, CW = 16, FR = 4;
  localparam int TW = $clog2(MAXT+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wv = 1'b0;
  logic [TW-1:0] taps = '0;
  logic [WW-1:0] wd = '0;
  logic rdy, we, done;
  logic [TW-1:0] waddr;
  logic [CW-1:0] wdata;

  wcb_coef_builder #(.IDEAL_DEPTH(DEPTH), .MAX_TAPS(MAXT), .WIN_W(WW),
                     .COEF_W(CW), .FRAC(FR)) u_wcb_coef_builder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .taps_i(taps),
    .win_valid_i(wv), .win_ready_o(rdy), .win_data_i(wd),
    .coef_we_o(we), .coef_addr_o(waddr), .coef_data_o(wdata), .done_o(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int win_hist[MAXT];
  int wr_count, done_count, done_cyc, last_wr_cyc, start_cyc, run_n, run_base;
  string cur_tag = "R3";
  bit finished = 0;

  function automatic int ideal(int k);
    return ((k * 1237 + 91) % 65536) - 32768;
  endfunction

  function automatic int expect_coef(int k, int w);
    int p, r;
    p = ideal(k) * w;
    r = (p + (1 << (FR-1))) >>> FR;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int golomb(int i);
    int g[MAXT+2];
    g[1] = 1;
    for (int n = 2; n <= i + 1; n++) g[n] = 1 + g[n - g[g[n-1]]];
    return g[i+1];
  endfunction

  function automatic int winval(int pat, int i);
    case (pat)
      0: return golomb(i);
      1: return 1;
      2: return 255;
      default: return (i * 17 + 3) % 256;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (we) begin
        chk(int'(waddr) == wr_count, "R2 write order", int'(waddr), wr_count);
        if (int'(waddr) < MAXT)
          chk(int'($signed(wdata)) == expect_coef(run_base + int'(waddr), win_hist[waddr]),
              cur_tag, int'($signed(wdata)),
              expect_coef(run_base + int'(waddr), win_hist[waddr]));
        wr_count++;
        last_wr_cyc = cyc;
      end
      if (done) begin
        done_count++;
        done_cyc = cyc;
      end
    end
  end

  task automatic begin_run(int t);
    @(negedge clk);
    taps = TW'(t); start = 1'b1; wv = 1'b0;
    #1 chk(rdy == 1'b0, "R10 ready low in start cycle", int'(rdy), 0);
    @(posedge clk);
    #1;
    wr_count = 0; done_count = 0; done_cyc = -1; last_wr_cyc = -1;
    start_cyc = cyc;
    run_n = (t > MAXT) ? MAXT : t;
    run_base = DEPTH/2 - run_n/2;
    @(negedge clk);
    start = 1'b0;
    chk(we == 1'b0, "R9 no write after start", int'(we), 0);
    #1 chk(rdy == (run_n > 0), "R2 ready after start", int'(rdy), int'(run_n > 0));
  endtask

  task automatic feed(int pat, int gap, int limit);
    int i = 0;
    bit acc;
    while (i < limit) begin
      @(negedge clk);
      if (gap != 0 && (cyc % 3 == 0)) wv = 1'b0;
      else begin
        wv = 1'b1;
        wd = WW'(winval(pat, i));
        win_hist[i] = winval(pat, i);
      end
      #1 acc = wv && rdy;
      @(posedge clk);
      if (acc) i++;
    end
  endtask

  task automatic finish_run(string cnt_tag);
    @(negedge clk) wv = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_count == run_n, cnt_tag, wr_count, run_n);
    chk(done_count == 1, "R7 single done", done_count, 1);
    if (run_n > 0) chk(done_cyc == last_wr_cyc + 1, "R7 done timing", done_cyc, last_wr_cyc + 1);
    else           chk(done_cyc == start_cyc + 1, "R7 zero-tap done", done_cyc, start_cyc + 1);
  endtask

  task automatic report();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy == 0 && we == 0 && done == 0, "R1 reset outputs", int'({rdy, we, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy == 0 && we == 0 && done == 0, "R1 after reset", int'({rdy, we, done}), 0);

    // Sweep all tap counts including clamped ones (R8), patterns R3/R4/R5, gaps R6
    for (int t = 0; t <= MAXT + 2; t++) begin
      int pat = t % 4;
      cur_tag = (pat == 1) ? "R4 rounding" : (pat == 2) ? "R5 saturation" :
                ((t % 2) != 0) ? "R6 gapped stream" : "R3 product";
      begin_run(t);
      feed(pat, t % 2, run_n);
      finish_run((t > MAXT) ? "R8 clamp count" : "R2 write count");
    end

    // R10: beats offered while idle are ignored
    @(negedge clk);
    wv = 1'b1; wd = 8'd9;
    #1 chk(rdy == 1'b0, "R10 idle ready", int'(rdy), 0);
    repeat (3) @(negedge clk);
    chk(wr_count == run_n, "R10 no idle write", wr_count, run_n);
    wv = 1'b0;

    // R9: abort a build mid-way, restart with fewer taps
    cur_tag = "R9 restarted data";
    begin_run(10);
    feed(3, 0, 4);
    begin_run(5);
    feed(0, 0, run_n);
    finish_run("R9 restart count");

    report();
  end
endmodule